// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block is the digital control core of a high-speed CAN physical-layer interface. It runs on a local system clock. Its inputs are the transmit line from the protocol controller, a standby select, a digitized bus-dominant flag from an external comparator, and an overtemperature flag. Its outputs are a dominant-drive enable for the analog driver and the receive line back to the controller.

In normal mode a low transmit line drives the bus dominant, and the receive line mirrors the bus. A guard timer limits how long one continuous low on the transmit line can hold the bus. Once the guard has tripped, the driver stays off until the transmit line rises again. In standby the driver is always off. Bus activity reaches the receive line only when a dominant level lasts long enough, so a sleeping controller can be woken without glitches.

The timeout length and the standby filter length are parameters counted in clock cycles. The timeout should cover at least eleven bit times at the slowest data rate in use. This gives a minimum data rate of eleven divided by the timeout.

Top module: `can_phy_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, the block is in standby with `drv_dom_o` = 0 and `rxd_o` = 1.
- R2: In normal mode (`stby_i` = 0), `txd_i` = 0 gives `drv_dom_o` = 1 and `txd_i` = 1 gives `drv_dom_o` = 0. The response comes two clock edges after the input, through a two-flop synchronizer.
- R3: With `stby_i` = 1, `drv_dom_o` stays 0 whatever `txd_i` does.
- R4: In normal mode, `rxd_o` is the inverse of `bus_dom_i`, with three clock edges of latency. A dominant pulse of L cycles gives exactly L cycles of `rxd_o` = 0.
- R5: In standby, `rxd_o` goes low only once `bus_dom_i` has been 1 for FILT_CYCLES consecutive cycles. A dominant pulse of L cycles gives max(0, L − FILT_CYCLES + 1) cycles of `rxd_o` = 0, so shorter pulses leave it high.
- R6: In normal mode, a falling edge of the synchronized transmit line arms the timer. A transmit line that is already low when normal mode is entered also arms it. A continuous low of L cycles then drives dominant for exactly min(L, TO_CYCLES) cycles.
- R7: After the timeout trips, `drv_dom_o` stays 0 while `txd_i` stays low. Only a rising edge of `txd_i` clears the lockout.
- R8: During a lockout, `rxd_o` keeps following `bus_dom_i` as in R4.
- R9: `ot_i` = 1 forces `drv_dom_o` = 0 in the same cycle, whatever the mode and `txd_i`. It does not disturb the timer.
- R10: Entering standby clears any armed timer and any lockout.
- R11: Any recessive cycle restarts the standby filter. Two dominant pulses of FILT_CYCLES − 1 cycles, separated by one recessive cycle, leave `rxd_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit data from the protocol controller, 0 = dominant |
| stby_i | input | 1 | Standby select, 1 = standby |
| bus_dom_i | input | 1 | Digitized bus state from the comparator, 1 = dominant |
| ot_i | input | 1 | Overtemperature flag, 1 = force driver off |
| drv_dom_o | output | 1 | Driver enable, 1 = drive the bus dominant |
| rxd_o | output | 1 | Receive data to the protocol controller, 0 = dominant |

## Verification
Two functions can act in the same cycle: the timeout lockout on the transmit path and the receive path that mirrors the bus. The bench holds the transmit line low past the timeout and then pulses the bus-dominant input. It expects `drv_dom_o` to stay 0 and `rxd_o` to show exactly the pulse length. A second collision, between overtemperature and an active dominant drive, is provoked by raising `ot_i` in the middle of a low transmit pulse. There the drive count is expected to drop by exactly the number of overtemperature cycles. Every length sweep compares counted output cycles with min(L, TO_CYCLES) or max(0, L − FILT_CYCLES + 1).

// File: rtl/can_phy_pkg.sv
package can_phy_pkg;
  typedef enum logic {
    MODE_STBY = 1'b0,
    MODE_NORM = 1'b1
  } phy_mode_e;
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/txd_timeout.sv
module txd_timeout #(
  parameter int unsigned TO_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic normal_i,
  input  logic txd_s_i,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(TO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TO_CYCLES - 1);

  logic          prev_q, armed_q, lock_q;
  logic [CW-1:0] cnt_q;
  logic          fall, rise;

  // prev_q held high outside normal mode: a low line at mode entry acts as a fall
  assign fall = prev_q & ~txd_s_i;
  assign rise = ~prev_q & txd_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (!normal_i) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q <= txd_s_i;
      if (rise) begin
        armed_q <= 1'b0;
        lock_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (fall) begin
        armed_q <= 1'b1;
        cnt_q   <= CW'(1);
      end else if (armed_q && !lock_q) begin
        if (cnt_q == LAST) lock_q <= 1'b1;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  assert_lock_on_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> !$past(txd_s_i));

  assert_lock_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> ($past(txd_s_i) || !$past(normal_i)));
endmodule

// File: rtl/stby_rx_filter.sv
module stby_rx_filter #(
  parameter int unsigned FILT_CYCLES = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic normal_i,
  input  logic bus_s_i,
  output logic rxd_o
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] fcnt_q;
  logic          rxd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      rxd_q  <= 1'b1;
    end else begin
      if (normal_i || !bus_s_i) fcnt_q <= '0;
      else if (fcnt_q != LAST)  fcnt_q <= fcnt_q + 1'b1;
      rxd_q <= normal_i ? ~bus_s_i : ~(bus_s_i && fcnt_q == LAST);
    end
  end

  assign rxd_o = rxd_q;

  assert_fcnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_q <= LAST);

  assert_stby_low_needs_dom_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!normal_i) && !rxd_q) |-> $past(bus_s_i));
endmodule

// File: rtl/can_phy_ctrl.sv
module can_phy_ctrl
  import can_phy_pkg::*;
#(
  parameter int unsigned TO_CYCLES   = 4096,
  parameter int unsigned FILT_CYCLES = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic stby_i,
  input  logic bus_dom_i,
  input  logic ot_i,
  output logic drv_dom_o,
  output logic rxd_o
);
  logic [2:0] raw, sync;
  logic       txd_s, stby_s, bus_s, lock;
  phy_mode_e  mode;

  assign raw = {txd_i, stby_i, bus_dom_i};

  cdc_sync #(.W(3), .RST_VAL(3'b110)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (sync)
  );

  assign {txd_s, stby_s, bus_s} = sync;
  assign mode = stby_s ? MODE_STBY : MODE_NORM;

  txd_timeout #(.TO_CYCLES(TO_CYCLES)) i_timeout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .normal_i(mode == MODE_NORM),
    .txd_s_i (txd_s),
    .lock_o  (lock)
  );

  stby_rx_filter #(.FILT_CYCLES(FILT_CYCLES)) i_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .normal_i(mode == MODE_NORM),
    .bus_s_i (bus_s),
    .rxd_o   (rxd_o)
  );

  // overtemperature acts without a clock so the driver drops at once
  assign drv_dom_o = (mode == MODE_NORM) & ~txd_s & ~lock & ~ot_i;

  assert_stby_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_dom_o |-> !$past(stby_i, 2));

  assert_lock_blocks_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> !drv_dom_o);
endmodule

// File: tb/test_can_phy_ctrl.sv
module test_can_phy_ctrl;
  localparam int TO = 12;
  localparam int FL = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic txd = 1'b1, stby = 1'b1, bus = 1'b0, ot = 1'b0;
  logic drv, rxd;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  can_phy_ctrl #(.TO_CYCLES(TO), .FILT_CYCLES(FL)) i_can_phy_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .txd_i(txd), .stby_i(stby),
    .bus_dom_i(bus), .ot_i(ot), .drv_dom_o(drv), .rxd_o(rxd)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which=0: txd low for L cycles; which=1: bus dominant for L cycles
  task automatic pulse(input bit which, input int len, input int win,
                       output int drv_cnt, output int rx_low);
    drv_cnt = 0; rx_low = 0;
    if (which) bus = 1'b1; else txd = 1'b0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      drv_cnt += int'(drv);
      rx_low  += int'(!rxd);
      if (i + 1 == len) begin
        if (which) bus = 1'b0; else txd = 1'b1;
      end
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int d, r;
    idle(3);
    chk("R1 drv in reset", int'(drv), 0);
    chk("R1 rxd in reset", int'(rxd), 1);
    rst_ni = 1'b1;
    idle(3);
    chk("R1 drv after reset", int'(drv), 0);
    chk("R1 rxd after reset", int'(rxd), 1);

    // R3: standby ignores txd
    for (int len = 1; len <= TO + 2; len += 3) begin
      pulse(1'b0, len, len + 6, d, r);
      chk("R3 standby drive count", d, 0);
    end

    // R5: standby filter sweep
    for (int len = 1; len <= FL + 3; len++) begin
      pulse(1'b1, len, len + 8, d, r);
      chk("R5 standby rxd low count", r, (len >= FL) ? len - FL + 1 : 0);
    end

    // R11: split pulses do not add up
    bus = 1'b1; idle(FL - 1); bus = 1'b0; idle(1);
    pulse(1'b1, FL - 1, FL + 6, d, r);
    chk("R11 split pulses rxd low count", r, 0);

    // enter normal mode
    stby = 1'b0; idle(5);
    chk("R2 idle recessive drv", int'(drv), 0);

    // R4: normal receive follows the bus
    for (int len = 1; len <= 5; len++) begin
      pulse(1'b1, len, len + 6, d, r);
      chk("R4 normal rxd low count", r, len);
    end

    // R2/R6: timeout sweep
    for (int len = 1; len <= TO + 3; len++) begin
      pulse(1'b0, len, len + 8, d, r);
      if (len < TO) chk("R2 drive count short pulse", d, len);
      else          chk("R6 drive count capped", d, imin(len, TO));
      idle(2);
    end

    // R7 and R8: lockout holds while txd stays low, receive still works
    txd = 1'b0; idle(TO + 5);
    chk("R7 locked drv", int'(drv), 0);
    pulse(1'b1, 4, 10, d, r);
    chk("R7 locked drive count", d, 0);
    chk("R8 rxd during lockout", r, 4);
    txd = 1'b1; idle(3);
    pulse(1'b0, 3, 10, d, r);
    chk("R7 drive after rise", d, 3);
    idle(3);

    // R10: standby clears lockout; re-entry with txd low arms a fresh timer
    txd = 1'b0; idle(TO + 5);
    chk("R10 locked before standby", int'(drv), 0);
    stby = 1'b1; idle(5);
    stby = 1'b0;
    d = 0;
    for (int i = 0; i < TO + 8; i++) begin
      @(negedge clk);
      d += int'(drv);
    end
    chk("R10 drive count after re-entry with low txd", d, TO);
    txd = 1'b1; idle(3);
    stby = 1'b1; txd = 1'b0; idle(TO + 5);
    stby = 1'b0; txd = 1'b1; idle(4);
    pulse(1'b0, 4, 10, d, r);
    chk("R10 drive after standby clear", d, 4);
    idle(3);

    // R9: overtemperature cuts the drive at once, timer unaffected
    txd = 1'b0; d = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == 3) ot = 1'b1;
      if (i == 6) ot = 1'b0;
      #1;
      if (ot) chk("R9 drv with overtemp", int'(drv), 0);
      d += int'(drv);
      if (i + 1 == 8) txd = 1'b1;
    end
    chk("R9 drive count with overtemp", d, 5);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule